// File: doc/BRIEF.md
# One-Shot Delayed Pulse Timer

This block is a 16-bit timer that turns each accepted trigger into one output pulse. The pulse starts after a programmable delay and has a programmable width. While the timer is enabled and idle, its counter sits at all-ones and waits. A trigger comes from one of two sources: a software strobe, or a selected edge on an external pin. The external pin is synchronized before its edge is detected.

When a trigger is accepted, two buffer registers capture the two compare values presented by software. The counter then wraps to zero and advances once per count-enable tick from an outside prescaler. The output turns on when the count reaches the start compare. It stays on through the count equal to the end compare. On the tick after that, the counter goes back to all-ones and stops. Each buffered compare value raises its own one-cycle match flag. Triggers that arrive during a sequence are dropped.

Top module: `oneshot_timer`

## Requirements
- R1: While enabled and idle, `count_o` holds 16'hFFFF and does not advance on ticks.
- R2: A trigger is a one-cycle `sw_trig_i` strobe or a selected edge on `ext_trig_i`. A trigger received while `enable_i` is low has no effect.
- R3: `edge_sel_i` selects the external edge: 0 = none, 1 = rising, 2 = falling, 3 = both. The pin passes through a two-flop synchronizer before edge detection.
- R4: On an accepted trigger, `count_o` becomes 0 at the next clock edge. After that it increments by one on each clock where `tick_i` is high.
- R5: With start compare S and end compare E, `pulse_o` goes high S ticks after acceptance and stays high for E−S+1 ticks. If S > E, no pulse is produced.
- R6: On the tick after the count equals E, `count_o` returns to 16'hFFFF and the timer waits for a new trigger.
- R7: A trigger that arrives while a sequence is running is ignored. The running pulse keeps its timing.
- R8: `irq_end_o` is high for exactly one cycle, the first cycle in which `count_o` equals the buffered end compare. `irq_start_o` behaves the same way for the buffered start compare.
- R9: The compare values are captured at trigger acceptance. A change to `cmp_end_i` or `cmp_start_i` during a pulse affects only the next pulse.
- R10: Dropping `enable_i` clears a running sequence. From the next clock `pulse_o` is low and `count_o` is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Timer enable |
| tick_i | input | 1 | Count-enable tick from prescaler |
| edge_sel_i | input | 2 | External edge select (0 none, 1 rise, 2 fall, 3 both) |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| sw_trig_i | input | 1 | Software trigger strobe |
| cmp_end_i | input | 16 | End compare value (pulse ends after this count) |
| cmp_start_i | input | 16 | Start compare value (delay) |
| pulse_o | output | 1 | One-shot pulse output |
| irq_end_o | output | 1 | End compare match flag |
| irq_start_o | output | 1 | Start compare match flag |
| count_o | output | 16 | Counter value |

## Verification
The hardest cases to reach are those where something happens during a running sequence. One is a second trigger arriving mid-pulse; another is a compare value changing after it has been buffered. The bench produces these by injecting a strobe and rewriting `cmp_end_i` at a chosen sample inside the measurement loop of a pulse. It then fires again to show that the new value takes effect. A full sweep of small start/end pairs, including start greater than end, checks the delay, the width and where each match flag falls. A slow-tick run confirms that the width scales with the tick rate.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/oneshot_edge_det.sv
module oneshot_edge_det
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  edge_sel_e sel_i,
  input  logic      pin_i,
  output logic      edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: edge_o = cur & ~prev_q;
      EDGE_FALL: edge_o = ~cur & prev_q;
      EDGE_BOTH: edge_o = cur ^ prev_q;
      default:   edge_o = 1'b0;
    endcase
  end

  // edge needs a change between synchronized samples
  assert_edge_needs_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (cur != prev_q));
endmodule

// File: rtl/oneshot_core.sv
module oneshot_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cmp_end_i,
  input  logic [CNT_W-1:0] cmp_start_i,
  output logic             pulse_o,
  output logic             irq_end_o,
  output logic             irq_start_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, end_q, start_q;
  logic [CNT_W-1:0] cnt_d, end_d, start_d;
  logic             chg, accept, adv, done;

  assign accept = enable_i & ~run_q & trig_i;
  assign adv    = run_q & tick_i;
  assign done   = adv & (cnt_q == end_q);

  always_comb begin
    cnt_d   = cnt_q;
    end_d   = end_q;
    start_d = start_q;
    chg     = 1'b0;
    if (!enable_i) begin
      cnt_d = ONES;
    end else if (accept) begin
      cnt_d   = '0;
      end_d   = cmp_end_i;
      start_d = cmp_start_i;
      chg     = 1'b1;
    end else if (done) begin
      cnt_d = ONES;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      chg   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      cnt_q       <= ONES;
      end_q       <= '0;
      start_q     <= '0;
      irq_end_o   <= 1'b0;
      irq_start_o <= 1'b0;
    end else begin
      run_q       <= enable_i & (accept | (run_q & ~done));
      cnt_q       <= cnt_d;
      end_q       <= end_d;
      start_q     <= start_d;
      irq_end_o   <= chg & (cnt_d == end_d);
      irq_start_o <= chg & (cnt_d == start_d);
    end
  end

  assign pulse_o = run_q & (cnt_q >= start_q);
  assign count_o = cnt_q;

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !accept) |=> (count_o == ONES));
  assert_start_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (count_o == '0));
  assert_ignore_retrig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && enable_i && !tick_i) |=> ($stable(count_o) && $stable(end_q)));
  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_end_o |=> !irq_end_o);
  assert_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!pulse_o && count_o == ONES));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             ext_trig_i,
  input  logic             sw_trig_i,
  input  logic [CNT_W-1:0] cmp_end_i,
  input  logic [CNT_W-1:0] cmp_start_i,
  output logic             pulse_o,
  output logic             irq_end_o,
  output logic             irq_start_o,
  output logic [CNT_W-1:0] count_o
);
  logic ext_edge;
  logic trig;

  oneshot_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (edge_sel_e'(edge_sel_i)),
    .pin_i  (ext_trig_i),
    .edge_o (ext_edge)
  );

  assign trig = ext_edge | sw_trig_i;

  oneshot_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .tick_i      (tick_i),
    .trig_i      (trig),
    .cmp_end_i   (cmp_end_i),
    .cmp_start_i (cmp_start_i),
    .pulse_o     (pulse_o),
    .irq_end_o   (irq_end_o),
    .irq_start_o (irq_start_o),
    .count_o     (count_o)
  );
endmodule

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        tick_i = 1'b1;
  logic [1:0]  edge_sel_i = 2'd0;
  logic        ext_trig_i = 1'b0;
  logic        sw_trig_i = 1'b0;
  logic [15:0] cmp_end_i = '0;
  logic [15:0] cmp_start_i = '0;
  logic        pulse_o, irq_end_o, irq_start_o;
  logic [15:0] count_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit slow_tick = 1'b0;
  int tick_ph = 0;
  int starts = 0;
  logic pulse_prev = 1'b0;

  oneshot_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .tick_i(tick_i),
    .edge_sel_i(edge_sel_i), .ext_trig_i(ext_trig_i), .sw_trig_i(sw_trig_i),
    .cmp_end_i(cmp_end_i), .cmp_start_i(cmp_start_i), .pulse_o(pulse_o),
    .irq_end_o(irq_end_o), .irq_start_o(irq_start_o), .count_o(count_o)
  );

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (slow_tick) begin
      tick_i  <= (tick_ph == 0);
      tick_ph <= (tick_ph == 2) ? 0 : tick_ph + 1;
    end else begin
      tick_i <= 1'b1;
    end
    if (pulse_o && !pulse_prev) starts <= starts + 1;
    pulse_prev <= pulse_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fires sw trigger; k = samples after acceptance edge; optional injection at sample inj
  task automatic fire(input int n, input int inj, input logic [15:0] new_end,
                      output int dly, output int wid, output int ie_n, output int ie_k,
                      output int is_n, output int is_k);
    dly = -1; wid = 0; ie_n = 0; ie_k = -1; is_n = 0; is_k = -1;
    @(negedge clk_i); sw_trig_i = 1'b1;
    @(negedge clk_i); sw_trig_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (pulse_o) begin wid++; if (dly < 0) dly = k; end
      if (irq_end_o) begin ie_n++; ie_k = k; end
      if (irq_start_o) begin is_n++; is_k = k; end
      if (k == inj) begin sw_trig_i = 1'b1; cmp_end_i = new_end; end
      else sw_trig_i = 1'b0;
      @(negedge clk_i);
    end
    sw_trig_i = 1'b0;
  endtask

  task automatic ext_case(input logic [1:0] sel, input logic lvl, input int exp_starts,
                          input string req);
    int s0;
    edge_sel_i = sel;
    repeat (4) @(negedge clk_i);
    s0 = starts;
    ext_trig_i = lvl;
    repeat (20) @(negedge clk_i);
    check(req, starts - s0, exp_starts);
    check(req, count_o, 16'hFFFF);
  endtask

  initial begin
    int dly, wid, ie_n, ie_k, is_n, is_k;
    repeat (3) @(negedge clk_i);
    check("R1 reset count", count_o, 16'hFFFF);
    check("R1 reset outputs", {pulse_o, irq_end_o, irq_start_o}, 3'b000);
    rst_ni = 1'b1;

    // disabled: trigger ignored
    cmp_start_i = 16'd1; cmp_end_i = 16'd3;
    fire(10, -1, 16'd0, dly, wid, ie_n, ie_k, is_n, is_k);
    check("R2 disabled trigger ignored", wid, 0);
    check("R2 disabled count", count_o, 16'hFFFF);

    enable_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R1 idle hold", count_o, 16'hFFFF);

    // sweep start/end pairs
    for (int s = 0; s < 6; s++) begin
      for (int e = 0; e < 8; e++) begin
        cmp_start_i = 16'(s); cmp_end_i = 16'(e);
        fire(20, -1, 16'd0, dly, wid, ie_n, ie_k, is_n, is_k);
        if (s <= e) begin
          check("R5 delay", dly, s);
          check("R5 width", wid, e - s + 1);
          check("R8 start flag", {is_n, is_k}, {32'd1, 32'(s)});
        end else begin
          check("R5 no pulse when start>end", wid, 0);
          check("R8 start flag absent", is_n, 0);
        end
        check("R8 end flag", {ie_n, ie_k}, {32'd1, 32'(e)});
        check("R6 return to idle", count_o, 16'hFFFF);
      end
    end

    // count progression
    cmp_start_i = 16'd3; cmp_end_i = 16'd9;
    @(negedge clk_i); sw_trig_i = 1'b1;
    @(negedge clk_i); sw_trig_i = 1'b0;
    check("R4 zero after trigger", count_o, 16'd0);
    @(negedge clk_i);
    check("R4 increment", count_o, 16'd1);
    repeat (12) @(negedge clk_i);

    // retrigger + compare change mid-pulse
    cmp_start_i = 16'd2; cmp_end_i = 16'd6;
    fire(20, 4, 16'd10, dly, wid, ie_n, ie_k, is_n, is_k);
    check("R7 retrigger ignored width", wid, 5);
    check("R7 retrigger ignored start", dly, 2);
    check("R9 buffered end flag", ie_k, 6);
    fire(24, -1, 16'd0, dly, wid, ie_n, ie_k, is_n, is_k);
    check("R9 new end takes effect", wid, 9);

    // slow tick
    slow_tick = 1'b1;
    cmp_start_i = 16'd2; cmp_end_i = 16'd4;
    repeat (3) @(negedge clk_i);
    fire(40, -1, 16'd0, dly, wid, ie_n, ie_k, is_n, is_k);
    check("R4 slow tick width", wid, 9);
    check("R8 slow tick single flags", {ie_n, is_n}, {32'd1, 32'd1});
    slow_tick = 1'b0;
    repeat (3) @(negedge clk_i);

    // enable drop mid-pulse
    cmp_start_i = 16'd1; cmp_end_i = 16'd20;
    @(negedge clk_i); sw_trig_i = 1'b1;
    @(negedge clk_i); sw_trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R10 pulse high before drop", pulse_o, 1'b1);
    enable_i = 1'b0;
    @(negedge clk_i);
    check("R10 pulse cleared", pulse_o, 1'b0);
    check("R10 count parked", count_o, 16'hFFFF);
    enable_i = 1'b1;
    repeat (30) @(negedge clk_i);
    check("R10 stays idle", count_o, 16'hFFFF);

    // external edges
    cmp_start_i = 16'd1; cmp_end_i = 16'd3;
    ext_case(2'd1, 1'b1, 1, "R3 rising accepted");
    ext_case(2'd1, 1'b0, 0, "R3 falling ignored in rise mode");
    ext_case(2'd2, 1'b1, 0, "R3 rising ignored in fall mode");
    ext_case(2'd2, 1'b0, 1, "R3 falling accepted");
    ext_case(2'd3, 1'b1, 1, "R3 both rise");
    ext_case(2'd3, 1'b0, 1, "R3 both fall");
    ext_case(2'd0, 1'b1, 0, "R3 none mode");
    ext_case(2'd0, 1'b0, 0, "R3 none mode fall");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule